// File: doc/BRIEF.md
# Fetch-Group Branch Mispredict Detector

This block sits in the decode stage of a superscalar pipeline. It watches a whole fetch group as that group moves from the fetch buffer into the decode buffer. For every branch in the group, it infers the real direction of the branch from the address of the instruction that follows it. A follower that sits one fixed step past the branch means the branch fell through. Any other follower address means the branch was taken.

The block compares the inferred direction with the direction an external per-address predictor gave for that branch. It issues one predictor-update lane per branch it evaluates. On any disagreement it raises a sticky stall, and that stall blocks all further transfers until the execute stage reports that the branch has resolved.

A branch can sit in the last valid slot of a group, so its follower has not arrived yet. In that case the block keeps the branch and its prediction aside. It evaluates that branch against slot 0 of the next group that transfers.

The whole group transfers in one cycle or not at all. The predictor supplies one prediction per slot, aligned with the slot addresses. Update lane 0 belongs to the carried branch. Update lane k (k ≥ 1) belongs to the pair formed by slot k-1 and slot k.

Top module: `branch_mispredict_detector`

## Requirements
- R1: `xferFire` is 1 exactly when `grpCount` is nonzero, `decFull` is 0 and `stallActive` is 0. `grpCount` never exceeds the group width.
- R2: An evaluated branch's actual direction (`updActual`) is 0 (not taken) when the follower's address equals the branch address plus `NT_STEP` (default 8), and 1 otherwise.
- R3: A mispredict occurs when a lane's prediction differs from its actual direction during a transfer. It pulses `mispredict` in that cycle and sets `stallActive` from the next cycle.
- R4: During a transfer, lane k of the update outputs reports the branch address, prediction and actual direction of every evaluated branch. Lane k's address sits at bits [k*32 +: 32]. Lane 0 is the carried branch. Lane k ≥ 1 is slot k-1 checked against slot k. No lane is valid without a transfer.
- R5: A lane whose earlier instruction is not a branch, or whose follower slot lies at or beyond `grpCount`, produces no update and no mispredict.
- R6: When the last valid slot of a transferred group holds a branch, that branch is carried and evaluated on lane 0 at the next transfer. A transfer whose last slot is not a branch leaves nothing carried.
- R7: A carried branch is kept unchanged through cycles without a transfer.
- R8: `stallActive` stays 1 until a cycle with `resolvePulse`, and is 0 from the following cycle. A `resolvePulse` while the stall is clear has no effect. No transfer happens in the cycle the pulse arrives.
- R9: Reset clears the stall and any carried branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpCount | input | 3 | Number of valid slots in the fetch group (0 = fetch buffer empty) |
| grpAddr | input | 128 | Slot addresses, slot i at bits [i*32 +: 32] |
| grpIsBranch | input | 4 | Bit i set when slot i holds a branch |
| predTaken | input | 4 | Predictor's direction for slot i's address (1 = taken) |
| decFull | input | 1 | Decode buffer cannot accept a group |
| resolvePulse | input | 1 | Execute stage reports the stalling branch resolved |
| xferFire | output | 1 | Group moves from fetch to decode this cycle |
| stallActive | output | 1 | Sticky mispredict stall |
| mispredict | output | 1 | A mispredict was detected this cycle |
| updValid | output | 4 | Predictor update valid per lane |
| updAddr | output | 128 | Branch address per lane, lane k at bits [k*32 +: 32] |
| updPred | output | 4 | Prediction used per lane |
| updActual | output | 4 | Inferred actual direction per lane |

## Verification
The block holds two pieces of state: the stall flag and the carried branch.

A stall flag that is wrong shows at the ports in the very next cycle. A stale set flag suppresses `xferFire` for a group that should move. A missed set lets a group through right after a mispredict.

A lost or stale carried branch stays hidden while no group transfers. It shows only at the next transfer, as a missing or spurious lane-0 update, a wrong `updAddr` or `updPred`, or a wrong mispredict decision. The bench therefore pairs every carry with a following transfer, including transfers separated by idle cycles and by reset.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef struct packed {
    logic xfer;
    logic setStall;
    logic savePend;
    logic clrPend;
  } bmdCtl_t;
endpackage

// File: rtl/bmd_datapath.sv
module bmd_datapath
  import bmd_pkg::*;
#(
  parameter int W       = 4,
  parameter int AW      = 32,
  parameter int NT_STEP = 8,
  localparam int CNT_W  = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bmdCtl_t           ctl,
  input  logic [CNT_W-1:0]  grpCount,
  input  logic [W*AW-1:0]   grpAddr,
  input  logic [W-1:0]      grpIsBranch,
  input  logic [W-1:0]      predTaken,
  output logic              anyMispred,
  output logic              lastIsBranch,
  output logic [W-1:0]      updValid,
  output logic [W*AW-1:0]   updAddr,
  output logic [W-1:0]      updPred,
  output logic [W-1:0]      updActual
);

  logic          pendValid;
  logic [AW-1:0] pendAddr;
  logic          pendPred;

  logic [W-1:0]          laneAct, laneBr, lanePred, laneActual, laneMis;
  logic [W-1:0][AW-1:0]  prevAddr, nextAddr;

  for (genvar k = 0; k < W; k++) begin : g_lane
    if (k == 0) begin : g_carry
      assign prevAddr[k] = pendAddr;
      assign laneBr[k]   = pendValid;
      assign lanePred[k] = pendPred;
      assign laneAct[k]  = (grpCount != '0);
    end else begin : g_pair
      assign prevAddr[k] = grpAddr[(k-1)*AW +: AW];
      assign laneBr[k]   = grpIsBranch[k-1];
      assign lanePred[k] = predTaken[k-1];
      assign laneAct[k]  = (CNT_W'(k) < grpCount);
    end
    assign nextAddr[k]          = grpAddr[k*AW +: AW];
    assign laneActual[k]        = (nextAddr[k] != prevAddr[k] + AW'(NT_STEP));
    assign updValid[k]          = ctl.xfer && laneAct[k] && laneBr[k];
    assign laneMis[k]           = updValid[k] && (lanePred[k] != laneActual[k]);
    assign updAddr[k*AW +: AW]  = prevAddr[k];
    assign updPred[k]           = lanePred[k];
    assign updActual[k]         = laneActual[k];
  end

  assign anyMispred = |laneMis;

  logic [AW-1:0] lastAddr;
  logic          lastPred;

  always_comb begin
    lastIsBranch = 1'b0;
    lastAddr     = '0;
    lastPred     = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (CNT_W'(i) + CNT_W'(1) == grpCount) begin
        lastIsBranch = grpIsBranch[i];
        lastAddr     = grpAddr[i*AW +: AW];
        lastPred     = predTaken[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendPred  <= 1'b0;
    end else if (ctl.savePend) begin
      pendValid <= 1'b1;
      pendAddr  <= lastAddr;
      pendPred  <= lastPred;
    end else if (ctl.clrPend) begin
      pendValid <= 1'b0;
    end
  end

  AST_UPD_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (|updValid) |-> ctl.xfer);                                   // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.xfer |=> ($stable(pendValid) && $stable(pendAddr)));     // R7
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.xfer && !lastIsBranch) |=> !pendValid);                  // R6

endmodule

// File: rtl/bmd_control.sv
module bmd_control
  import bmd_pkg::*;
#(
  parameter int W      = 4,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] grpCount,
  input  logic             decFull,
  input  logic             resolvePulse,
  input  logic             anyMispred,
  input  logic             lastIsBranch,
  output bmdCtl_t          ctl,
  output logic             stallQ
);

  always_comb begin
    ctl.xfer     = (grpCount != '0) && !decFull && !stallQ;
    ctl.setStall = ctl.xfer && anyMispred;
    ctl.savePend = ctl.xfer && lastIsBranch;
    ctl.clrPend  = ctl.xfer && !lastIsBranch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             stallQ <= 1'b0;
    else if (ctl.setStall) stallQ <= 1'b1;
    else if (resolvePulse) stallQ <= 1'b0;
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    grpCount <= CNT_W'(W));                                       // R1
  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.xfer && anyMispred) |=> stallQ);                         // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stallQ && !resolvePulse) |=> stallQ);                        // R8
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (stallQ && resolvePulse) |=> !stallQ);                        // R8
  AST_IDLE_RESOLVE: assert property (@(posedge clk) disable iff (!rstN)
    (!stallQ && !ctl.xfer) |=> !stallQ);                          // R8

endmodule

// File: rtl/branch_mispredict_detector.sv
module branch_mispredict_detector
  import bmd_pkg::*;
#(
  parameter int W       = 4,
  parameter int AW      = 32,
  parameter int NT_STEP = 8,
  localparam int CNT_W  = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  grpCount,
  input  logic [W*AW-1:0]   grpAddr,
  input  logic [W-1:0]      grpIsBranch,
  input  logic [W-1:0]      predTaken,
  input  logic              decFull,
  input  logic              resolvePulse,
  output logic              xferFire,
  output logic              stallActive,
  output logic              mispredict,
  output logic [W-1:0]      updValid,
  output logic [W*AW-1:0]   updAddr,
  output logic [W-1:0]      updPred,
  output logic [W-1:0]      updActual
);

  bmdCtl_t ctl;
  logic    anyMispred;
  logic    lastIsBranch;
  logic    stallQ;

  bmd_control #(.W(W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .grpCount     (grpCount),
    .decFull      (decFull),
    .resolvePulse (resolvePulse),
    .anyMispred   (anyMispred),
    .lastIsBranch (lastIsBranch),
    .ctl          (ctl),
    .stallQ       (stallQ)
  );

  bmd_datapath #(.W(W), .AW(AW), .NT_STEP(NT_STEP)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .grpCount     (grpCount),
    .grpAddr      (grpAddr),
    .grpIsBranch  (grpIsBranch),
    .predTaken    (predTaken),
    .anyMispred   (anyMispred),
    .lastIsBranch (lastIsBranch),
    .updValid     (updValid),
    .updAddr      (updAddr),
    .updPred      (updPred),
    .updActual    (updActual)
  );

  assign xferFire    = ctl.xfer;
  assign stallActive = stallQ;
  assign mispredict  = anyMispred;

endmodule

// File: tb/branch_mispredict_detector_tb.sv
module branch_mispredict_detector_tb_top;

  logic         clk = 1'b0;
  logic         rstN;
  logic [2:0]   grpCount;
  logic [127:0] grpAddr;
  logic [3:0]   grpIsBranch, predTaken;
  logic         decFull, resolvePulse;
  logic         xferFire, stallActive, mispredict;
  logic [3:0]   updValid, updPred, updActual;
  logic [127:0] updAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  branch_mispredict_detector dut_i (
    .clk(clk), .rstN(rstN), .grpCount(grpCount), .grpAddr(grpAddr),
    .grpIsBranch(grpIsBranch), .predTaken(predTaken), .decFull(decFull),
    .resolvePulse(resolvePulse), .xferFire(xferFire), .stallActive(stallActive),
    .mispredict(mispredict), .updValid(updValid), .updAddr(updAddr),
    .updPred(updPred), .updActual(updActual)
  );

  typedef struct packed {
    logic [2:0]  cnt;
    logic [31:0] a0, a1, a2, a3;
    logic [3:0]  br, pt;
    logic        full, res;
    logic        xf;
    logic [3:0]  uv, ua;
    logic        st;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0,   32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R1 empty
    '{3'd4, 32'h100, 32'h108, 32'h110, 32'h118, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0}, // R5 no branch
    '{3'd4, 32'h200, 32'h208, 32'h300, 32'h308, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b1, 4'b0100, 4'b0100, 1'b0}, // R2 taken ok
    '{3'd4, 32'h400, 32'h408, 32'h410, 32'h418, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b0000, 1'b1}, // R3 mispredict
    '{3'd4, 32'h0,   32'h0,   32'h0,   32'h0,   4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1}, // R1 stalled
    '{3'd0, 32'h0,   32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R8 release
    '{3'd4, 32'h0,   32'h0,   32'h0,   32'h0,   4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R1 decode full
    '{3'd3, 32'h500, 32'h508, 32'h600, 32'h0,   4'b1101, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b0000, 1'b0}, // R5 beyond count, R6 carry
    '{3'd2, 32'h700, 32'h708, 32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0001, 4'b0001, 1'b1}, // R6 carry mispredict
    '{3'd0, 32'h0,   32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R8 release
    '{3'd1, 32'h800, 32'h0,   32'h0,   32'h0,   4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0}, // R6 single branch carry
    '{3'd0, 32'h0,   32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R7 idle
    '{3'd1, 32'h808, 32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000, 1'b1}, // R7 carry kept, R2 fallthrough
    '{3'd4, 32'h0,   32'h0,   32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0}, // R8 no xfer on pulse
    '{3'd2, 32'h900, 32'h908, 32'h0,   32'h0,   4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b0}  // R6 carry consumed, R8 idle pulse
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [31:0] a0, a1, a2, a3,
                       input logic [3:0] br, pt, input logic full, res);
    grpCount = c; grpAddr = {a3, a2, a1, a0};
    grpIsBranch = br; predTaken = pt; decFull = full; resolvePulse = res;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    rstN = 1'b0;
    drive(3'd0, 0, 0, 0, 0, 4'b0, 4'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    check("R9", "stall after reset", 64'(stallActive), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VECS[v].cnt, VECS[v].a0, VECS[v].a1, VECS[v].a2, VECS[v].a3,
            VECS[v].br, VECS[v].pt, VECS[v].full, VECS[v].res);
      #2;
      check("R1", $sformatf("xfer vec %0d", v), 64'(xferFire), 64'(VECS[v].xf));
      check("R4", $sformatf("updValid vec %0d", v), 64'(updValid), 64'(VECS[v].uv));
      check("R2", $sformatf("updActual vec %0d", v), 64'(updActual & updValid), 64'(VECS[v].ua));
      @(posedge clk);
      #2;
      check("R3", $sformatf("stall vec %0d", v), 64'(stallActive), 64'(VECS[v].st));
    end

    // R4 carried lane contents: branch at 0xA08 predicted taken, follower at 0xB00
    @(negedge clk);
    drive(3'd2, 32'hA00, 32'hA08, 0, 0, 4'b0010, 4'b0010, 1'b0, 1'b0);
    #2;
    check("R6", "no lane for last-slot branch", 64'(updValid), 64'd0);
    @(negedge clk);
    drive(3'd1, 32'hB00, 0, 0, 0, 4'b0000, 4'b0000, 1'b0, 1'b0);
    #2;
    check("R4", "lane0 valid", 64'(updValid), 64'b0001);
    check("R4", "lane0 address", 64'(updAddr[31:0]), 64'h0A08);
    check("R4", "lane0 prediction", 64'(updPred[0]), 64'd1);
    check("R2", "lane0 actual taken", 64'(updActual[0]), 64'd1);
    check("R3", "no mispredict pulse", 64'(mispredict), 64'd0);

    // R9 reset drops stall and carried branch
    @(negedge clk);
    drive(3'd3, 32'hC00, 32'hC08, 32'hC10, 0, 4'b0101, 4'b0001, 1'b0, 1'b0);
    #2;
    check("R3", "mispredict pulse", 64'(mispredict), 64'd1);
    @(posedge clk);
    #2;
    check("R3", "stall set", 64'(stallActive), 64'd1);
    @(negedge clk);
    rstN = 1'b0;
    drive(3'd0, 0, 0, 0, 0, 4'b0, 4'b0, 1'b0, 1'b0);
    @(posedge clk);
    #2;
    check("R9", "stall cleared by reset", 64'(stallActive), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    drive(3'd1, 32'hD00, 0, 0, 0, 4'b0000, 4'b0000, 1'b0, 1'b0);
    #2;
    check("R9", "xfer after reset", 64'(xferFire), 64'd1);
    check("R9", "carry dropped by reset", 64'(updValid), 64'd0);
    @(negedge clk);
    drive(3'd0, 0, 0, 0, 0, 4'b0, 4'b0, 1'b0, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule